// File: doc/BRIEF.md
# Two-Sample Averaging Stream Filter

This block is a clocked streaming filter. It reads words over a four-phase request/acknowledge input channel. For each word it returns, over a four-phase request/acknowledge output channel, the mean of that word and the word before it. One history register holds the previous sample, and that register is zero after reset. The sum is formed by an adder one bit wider than the data, so it cannot overflow. A right shift then halves the sum, and the fraction is dropped.

The input word is captured into a holding register before the input acknowledge is raised. After that the sender may change the data freely. The adder's settling time is modelled as a fixed number of clock cycles set by a parameter. When that time has elapsed, the result is placed in an output register, and the output request is raised. The history register takes the new sample only once the receiver has acknowledged the result. At most one result is ever outstanding.

Top module: `avg2_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, in_ack and out_req are low and the history holds 0. The first result after reset is therefore the first input shifted right by one.
- R2: Each result equals (x + y) >> 1, where x is the current input and y is the history. The sum is computed W+1 bits wide, so the largest inputs do not overflow, and the fraction is truncated.
- R3: Once a result has been acknowledged, the history holds that result's input x, and the next result uses it as y.
- R4: in_data is sampled on the clock edge that raises in_ack. Values driven on in_data while in_ack is high do not change the result.
- R5: in_ack stays high while in_req stays high. It falls on the first edge at which in_req is seen low.
- R6: While out_req is high and out_ack is low, out_req stays high and out_data does not change.
- R7: out_req falls on the edge after out_ack is seen high. It is not raised again while out_ack remains high.
- R8: A new input is not acknowledged while a result is outstanding, which means while out_req or out_ack is high.
- R9: With out_ack low, out_req rises exactly ADD_LAT clock edges after the edge that raised in_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Input request: in_data is valid |
| in_ack | output | 1 | Input acknowledge: the sample has been captured |
| in_data | input | W | Input sample |
| out_req | output | 1 | Output request: out_data is valid |
| out_ack | input | 1 | Output acknowledge from the receiver |
| out_data | output | W | Averaged result |

## Verification
The bench drives all-ones and all-zero pairs. A design whose adder is only W bits wide wraps on the all-ones case and returns a small value instead of the maximum. After in_ack rises, the bench changes in_data to noise. A design that reads the input too late returns an average of the noise. The bench raises a new request while a result is still pending. A design without that interlock acknowledges the request early and loads the history in the wrong order. The bench also holds out_ack off for random lengths of time, to catch a result that changes or drops before it is taken. Finally, it counts the cycles from in_ack to out_req, to catch an adder latency that is off by one.

// File: rtl/avg2_pkg.sv
package avg2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SUM   = 2'd1,
    ST_OUT   = 2'd2,
    ST_DRAIN = 2'd3
  } avg2_state_t;
endpackage

// File: rtl/avg2_rst_sync.sv
module avg2_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/avg2_in_port.sv
module avg2_in_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_req,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         in_ack,
  output logic [W-1:0] x_q
);
  logic         ack_d;
  logic [W-1:0] x_d;

  always_comb begin
    ack_d = in_ack;
    if (take)        ack_d = 1'b1;
    else if (!in_req) ack_d = 1'b0;
    x_d = take ? in_data : x_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ack <= 1'b0;
      x_q    <= '0;
    end else begin
      in_ack <= ack_d;
      x_q    <= x_d;
    end
  end
endmodule

// File: rtl/avg2_hist.sv
module avg2_hist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] x_q,
  output logic [W-1:0] y_q
);
  logic [W-1:0] y_d;

  always_comb y_d = commit ? x_q : y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end
endmodule

// File: rtl/avg2_sum.sv
module avg2_sum #(
  parameter int W       = 8,
  parameter int ADD_LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x_q,
  input  logic [W-1:0] y_q,
  output logic         done,
  output logic [W-1:0] avg
);
  localparam int SW = W + 1;
  localparam int CW = (ADD_LAT > 1) ? $clog2(ADD_LAT) : 1;

  logic [SW-1:0] sum_full;
  logic          busy_q, busy_d;

  always_comb begin
    sum_full = {1'b0, x_q} + {1'b0, y_q};
    avg      = W'(sum_full >> 1);
  end

  generate
    if (ADD_LAT == 1) begin : g_lat_one
      always_comb begin
        done   = busy_q;
        busy_d = start ? 1'b1 : 1'b0;
      end
    end else begin : g_lat_cnt
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        done   = busy_q && (cnt_q == CW'(ADD_LAT - 1));
        busy_d = busy_q;
        cnt_d  = cnt_q;
        if (start) begin
          busy_d = 1'b1;
          cnt_d  = '0;
        end else if (done) begin
          busy_d = 1'b0;
        end else if (busy_q) begin
          cnt_d  = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end
endmodule

// File: rtl/avg2_out_port.sv
module avg2_out_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         release_req,
  input  logic [W-1:0] avg,
  output logic         out_req,
  output logic [W-1:0] out_data
);
  logic         req_d;
  logic [W-1:0] data_d;

  always_comb begin
    req_d  = out_req;
    data_d = out_data;
    if (load) begin
      req_d  = 1'b1;
      data_d = avg;
    end else if (release_req) begin
      req_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_req  <= 1'b0;
      out_data <= '0;
    end else begin
      out_req  <= req_d;
      out_data <= data_d;
    end
  end
endmodule

// File: rtl/avg2_ctrl.sv
module avg2_ctrl
  import avg2_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic in_ack,
  input  logic out_ack,
  input  logic sum_done,
  output logic take,
  output logic load,
  output logic release_req,
  output logic commit
);
  avg2_state_t st_q, st_d;

  always_comb begin
    st_d        = st_q;
    take        = 1'b0;
    load        = 1'b0;
    release_req = 1'b0;
    commit      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_req && !in_ack && !out_ack) begin
          take = 1'b1;
          st_d = ST_SUM;
        end
      end
      ST_SUM: begin
        if (sum_done) begin
          load = 1'b1;
          st_d = ST_OUT;
        end
      end
      ST_OUT: begin
        if (out_ack) begin
          release_req = 1'b1;
          commit      = 1'b1;
          st_d        = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!out_ack) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/avg2_filter.sv
module avg2_filter #(
  parameter int W       = 8,
  parameter int ADD_LAT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_req,
  output logic         in_ack,
  input  logic [W-1:0] in_data,
  output logic         out_req,
  input  logic         out_ack,
  output logic [W-1:0] out_data
);
  logic         rst_q_n;
  logic         take, load, release_req, commit, sum_done;
  logic [W-1:0] x_q, y_q, avg;

  avg2_rst_sync i_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  avg2_in_port #(.W(W)) i_in (
    .clk(clk), .rst_n(rst_q_n), .in_req(in_req), .in_data(in_data),
    .take(take), .in_ack(in_ack), .x_q(x_q)
  );

  avg2_hist #(.W(W)) i_hist (
    .clk(clk), .rst_n(rst_q_n), .commit(commit), .x_q(x_q), .y_q(y_q)
  );

  avg2_sum #(.W(W), .ADD_LAT(ADD_LAT)) i_sum (
    .clk(clk), .rst_n(rst_q_n), .start(take), .x_q(x_q), .y_q(y_q),
    .done(sum_done), .avg(avg)
  );

  avg2_out_port #(.W(W)) i_out (
    .clk(clk), .rst_n(rst_q_n), .load(load), .release_req(release_req),
    .avg(avg), .out_req(out_req), .out_data(out_data)
  );

  avg2_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_q_n), .in_req(in_req), .in_ack(in_ack),
    .out_ack(out_ack), .sum_done(sum_done), .take(take), .load(load),
    .release_req(release_req), .commit(commit)
  );
endmodule

// File: rtl/avg2_filter_chk.sv
module avg2_filter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_req,
  input logic         in_ack,
  input logic         out_req,
  input logic         out_ack,
  input logic [W-1:0] out_data
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!in_ack && !out_req);
    end
  end

  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && in_req |=> in_ack);

  p_ack_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && !in_req |=> !in_ack);

  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> out_req && $stable(out_data));

  p_out_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && out_ack |=> !out_req);

  p_no_rereq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req && out_ack |=> !out_req);

  p_one_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req || out_ack) && !in_ack |=> !in_ack);
endmodule

bind avg2_filter avg2_filter_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_q_n), .in_req(in_req), .in_ack(in_ack),
  .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
);

// File: tb/test_avg2_filter.sv
module test_avg2_filter;
  localparam int W   = 8;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_req, out_ack;
  logic [W-1:0] in_data;
  logic         in_ack, out_req;
  logic [W-1:0] out_data;

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  logic [W-1:0] hist_m;

  always #2 clk = ~clk;

  avg2_filter #(.W(W), .ADD_LAT(LAT)) i_avg2_filter (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .in_data(in_data), .out_req(out_req), .out_ack(out_ack),
    .out_data(out_data)
  );

  function automatic logic [W-1:0] exp_avg(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W:1];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One transfer; hold_n = cycles out_ack is withheld; early = present next
  // request while the result is pending.
  task automatic one_item(logic [W-1:0] x, int hold_n, bit early, logic [W-1:0] nx);
    int cyc;
    logic [W-1:0] ex, snap;
    ex = exp_avg(x, hist_m);
    if (!in_req) begin
      in_data = x;
      in_req  = 1'b1;
    end
    cyc = 0;
    while (!in_ack) begin @(negedge clk); cyc++; end
    // R4: scramble data once captured; R5: ack holds while req high
    in_data = W'($urandom);
    @(negedge clk);
    check(in_ack == 1'b1, "R5 ack held", in_ack, 1);
    in_req = 1'b0;
    cyc = 1;
    while (!out_req && cyc < 50) begin @(negedge clk); cyc++; end
    check(cyc == LAT, "R9 latency", cyc, LAT);
    @(negedge clk);
    check(in_ack == 1'b0, "R5 ack fall", in_ack, 0);
    check(out_data == ex, "R2/R3/R4 result", out_data, ex);
    snap = out_data;
    if (early) begin
      in_data = nx;
      in_req  = 1'b1;
    end
    for (int k = 0; k < hold_n; k++) begin
      @(negedge clk);
      check(out_req && out_data == snap, "R6 hold", out_data, snap);
      if (early) check(!in_ack, "R8 no early ack", in_ack, 0);
    end
    out_ack = 1'b1;
    @(negedge clk);
    check(!out_req, "R7 drop", out_req, 0);
    @(negedge clk);
    check(!out_req, "R7 no rereq", out_req, 0);
    if (early) check(!in_ack, "R8 ack while out_ack high", in_ack, 0);
    out_ack = 1'b0;
    hist_m = x;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd777));
    rst_n = 1'b0; in_req = 1'b0; out_ack = 1'b0; in_data = '0;
    hist_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!in_ack && !out_req, "R1 reset", {in_ack, out_req}, 0);
    // R1: first result uses zero history
    one_item(8'd201, 0, 0, 0);
    // R2 max values, no overflow
    one_item(8'hFF, 2, 0, 0);
    one_item(8'hFF, 0, 0, 0);
    one_item(8'h00, 1, 0, 0);
    one_item(8'h01, 0, 0, 0);
    // R8: next request while pending
    one_item(8'h80, 3, 1, 8'h7F);
    one_item(8'h7F, 0, 0, 0);
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      bit e;
      a = W'($urandom);
      b = W'($urandom);
      e = ($urandom % 4) == 0;
      one_item(a, int'($urandom % 4), e, b);
      if (e) one_item(b, 0, 0, 0);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule